// File: doc/BRIEF.md
# Wake-up interrupt pending aggregator

This block collects the interrupt sources that must still be able to wake the system while the main interrupt controller is powered down. It keeps a bank of 64 top-level source bits. Bit 0 carries the already-latched non-maskable interrupt. The following direct bits carry single peripheral lines. Every top-level bit from `FIRST_MUX` upward stands for a group of eight muxed lines. Each muxed line is gated by its own mux-enable bit before its group is ORed together. The top-level bit for muxed line m is `FIRST_MUX + m/8`.

Software sees three register banks through a simple 32-bit read/write port: pending words, enable words and mux-enable words. A pending bit reads as its source level ANDed with its enable. The single `wake_o` output is the OR of all enabled pending bits. Pending bits are never stored; they follow the sources. The only write side effect is a clear strobe for the non-maskable latch, which sits outside this block.

Top module: `wake_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every enable and mux-enable bit is 0, `wake_o` is 0 and `nmi_clr_o` is 0.
- R2: A write to an enable word (byte offset 0x40 + 4*n, n = 0..1) or a mux-enable word (byte offset 0xC0 + 4*n, n = 0..3) stores all 32 bits. A read of that word returns them.
- R3: Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and is held until the next read.
- R4: Pending word n (byte offset 0x10 + 4*n) returns top-level source bits 32n..32n+31 ANDed with enable word n. Bit 0 is `nmi_in`, and bits 1..FIRST_MUX-1 are `direct_in[0..]`.
- R5: Muxed line m counts toward top-level bit FIRST_MUX + m/8 only while mux-enable bit m (mux word m/32, bit m%32) is 1.
- R6: Top-level bits at or above FIRST_MUX + NUM_GROUPS always read as 0 in the pending words, even when enabled.
- R7: `wake_o` is the OR of all enabled pending bits and is registered. It is due one cycle after the source or enable change.
- R8: A write to pending word 0 with data bit 0 set makes `nmi_clr_o` high for exactly one cycle, in the cycle after the write. With data bit 0 clear there is no pulse.
- R9: Writes to pending words leave the direct and muxed pending bits unchanged.
- R10: Reads from undefined offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Latched non-maskable interrupt level (top-level bit 0) |
| direct_in | input | FIRST_MUX-1 | Direct lines, element i drives top-level bit i+1 |
| mux_in | input | NUM_GROUPS*8 | Muxed lines, line m feeds group m/8 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wake_o | output | 1 | Wake request, registered |
| nmi_clr_o | output | 1 | One-cycle clear strobe for the external NMI latch |

## Verification
Read data and `nmi_clr_o` are due one cycle after the edge that samples the strobe. `wake_o` is due one cycle after the edge that first sees a changed source or enable. Writes take effect at that same edge. The driver sets inputs on the falling edge and queues the expected word for each read. The monitor wakes on the following rising edge, waits 2 ns and compares `bus_rdata` against the head of the queue. Strobe and wake checks are made on the falling edge after that single register stage, and the strobe check is repeated one cycle later to confirm it has ended.

// File: rtl/wake_agg_pkg.sv
// Package: shared constants for the wake-up aggregator.
// Assumes byte addressing with 32-bit aligned registers.
package wake_agg_pkg;
    localparam int WORD_W     = 32;
    localparam int GROUP_W    = 8;
    localparam int PEND_BASE  = 'h10;
    localparam int EN_BASE    = 'h40;
    localparam int MUXEN_BASE = 'hC0;
endpackage

// File: rtl/wake_mux_group.sv
// Module: wake_mux_group
// Reduces one group of muxed lines to a single top-level source bit.
// Each line is gated by its own mux-enable bit. The module is purely combinational.
module wake_mux_group #(
    parameter int GROUP_W = 8
) (
    input  logic [GROUP_W-1:0] lines,
    input  logic [GROUP_W-1:0] line_en,
    output logic               hit
);
    // gate each line by its enable, then OR the group
    always_comb hit = |(lines & line_en);
endmodule

// File: rtl/wake_reg_bank.sv
// Module: wake_reg_bank
// Holds the enable and mux-enable words, decodes the register port and
// produces registered read data and the NMI clear strobe.
// Assumes TOP_BITS and MUX_BITS are multiples of 32. Pending data is supplied by the parent.
module wake_reg_bank
    import wake_agg_pkg::*;
#(
    parameter int TOP_BITS = 64,
    parameter int MUX_BITS = 128,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [TOP_BITS-1:0] pending,
    output logic [TOP_BITS-1:0] irq_en,
    output logic [MUX_BITS-1:0] mux_en,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                nmi_clr
);
    localparam int TOP_WORDS = TOP_BITS / WORD_W;
    localparam int MUX_WORDS = MUX_BITS / WORD_W;

    logic [WORD_W-1:0] en_words  [TOP_WORDS];
    logic [WORD_W-1:0] mux_words [MUX_WORDS];
    logic [WORD_W-1:0] rd_word;
    logic              addr_known;

    generate
        for (genvar w = 0; w < TOP_WORDS; w++) begin : g_en
            localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(EN_BASE + 4 * w);
            // enable word storage, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n)                         en_words[w] <= '0;
                else if (bus_wr && bus_addr == ADDR) en_words[w] <= bus_wdata;
            end
            assign irq_en[w*WORD_W +: WORD_W] = en_words[w];
        end
        for (genvar w = 0; w < MUX_WORDS; w++) begin : g_mux
            localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(MUXEN_BASE + 4 * w);
            // mux-enable word storage, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n)                         mux_words[w] <= '0;
                else if (bus_wr && bus_addr == ADDR) mux_words[w] <= bus_wdata;
            end
            assign mux_en[w*WORD_W +: WORD_W] = mux_words[w];
        end
    endgenerate

    // read multiplexer; undefined offsets give zero
    always_comb begin
        rd_word    = '0;
        addr_known = 1'b0;
        for (int w = 0; w < TOP_WORDS; w++) begin
            if (bus_addr == ADDR_W'(PEND_BASE + 4 * w)) begin
                rd_word    = pending[w*WORD_W +: WORD_W];
                addr_known = 1'b1;
            end
            if (bus_addr == ADDR_W'(EN_BASE + 4 * w)) begin
                rd_word    = en_words[w];
                addr_known = 1'b1;
            end
        end
        for (int w = 0; w < MUX_WORDS; w++) begin
            if (bus_addr == ADDR_W'(MUXEN_BASE + 4 * w)) begin
                rd_word    = mux_words[w];
                addr_known = 1'b1;
            end
        end
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // one-cycle clear strobe toward the external NMI latch
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_clr <= 1'b0;
        else        nmi_clr <= bus_wr && bus_addr == ADDR_W'(PEND_BASE) && bus_wdata[0];
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_en == '0 && mux_en == '0 && !nmi_clr));

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(EN_BASE)) |=> bus_rdata == $past(irq_en[WORD_W-1:0]));

    // R8
    nmi_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clr |-> $past(bus_wr && bus_addr == ADDR_W'(PEND_BASE) && bus_wdata[0]));

    // R10
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_known) |=> ($stable(irq_en) && $stable(mux_en)));
endmodule

// File: rtl/wake_aggregator.sv
// Module: wake_aggregator (top)
// Builds the top-level source vector from the NMI level, the direct lines and
// the muxed groups, masks it with the enables and drives a registered wake output.
// Assumes FIRST_MUX + NUM_GROUPS <= TOP_BITS and NUM_GROUPS*8 <= MUX_BITS.
module wake_aggregator
    import wake_agg_pkg::*;
#(
    parameter int TOP_BITS   = 64,
    parameter int MUX_BITS   = 128,
    parameter int FIRST_MUX  = 19,
    parameter int NUM_GROUPS = 13,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          nmi_in,
    input  logic [FIRST_MUX-2:0]          direct_in,
    input  logic [NUM_GROUPS*GROUP_W-1:0] mux_in,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output logic                          wake_o,
    output logic                          nmi_clr_o
);
    localparam int MUX_LINES = NUM_GROUPS * GROUP_W;

    logic [TOP_BITS-1:0]   raw;
    logic [TOP_BITS-1:0]   pending;
    logic [TOP_BITS-1:0]   irq_en;
    logic [MUX_BITS-1:0]   mux_en;
    logic [NUM_GROUPS-1:0] group_hit;

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            wake_mux_group #(.GROUP_W(GROUP_W)) i_grp (
                .lines   (mux_in[g*GROUP_W +: GROUP_W]),
                .line_en (mux_en[g*GROUP_W +: GROUP_W]),
                .hit     (group_hit[g])
            );
        end
    endgenerate

    // assemble top-level sources; unused upper bits stay zero
    always_comb begin
        raw = '0;
        raw[0] = nmi_in;
        raw[FIRST_MUX-1:1] = direct_in;
        raw[FIRST_MUX +: NUM_GROUPS] = group_hit;
    end

    // pending view: source level qualified by its enable
    always_comb pending = raw & irq_en;

    wake_reg_bank #(
        .TOP_BITS (TOP_BITS),
        .MUX_BITS (MUX_BITS),
        .ADDR_W   (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pending   (pending),
        .irq_en    (irq_en),
        .mux_en    (mux_en),
        .bus_rdata (bus_rdata),
        .nmi_clr   (nmi_clr_o)
    );

    // registered wake request
    always_ff @(posedge clk) begin
        if (!rst_n) wake_o <= 1'b0;
        else        wake_o <= |pending;
    end

    // R7
    wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_en) == '0) |-> !wake_o);

    // R5
    mux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en[MUX_LINES-1:0] == '0) |-> (pending[TOP_BITS-1:FIRST_MUX] == '0));

    // R1
    wake_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wake_o && !nmi_clr_o));
endmodule

// File: tb/test_wake_aggregator.sv
`timescale 1ns/1ps
module test_wake_aggregator;
    localparam int FIRST_MUX  = 19;
    localparam int NUM_GROUPS = 13;
    localparam int MUX_LINES  = NUM_GROUPS * 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 nmi_in = 1'b0;
    logic [FIRST_MUX-2:0] direct_in = '0;
    logic [MUX_LINES-1:0] mux_in = '0;
    logic                 bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]           bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 wake_o, nmi_clr_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string req; } item_t;
    item_t sb_q[$];

    logic [63:0]  en_m  = '0;
    logic [127:0] mux_m = '0;

    always #2.5 clk = ~clk;

    wake_aggregator i_wake_aggregator (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .direct_in(direct_in),
        .mux_in(mux_in), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_o(wake_o),
        .nmi_clr_o(nmi_clr_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected top-level pending vector from the requirement model
    function automatic logic [63:0] exp_pending();
        logic [63:0] r = '0;
        r[0] = nmi_in;
        r[FIRST_MUX-1:1] = direct_in;
        for (int g = 0; g < NUM_GROUPS; g++)
            r[FIRST_MUX+g] = |(mux_in[g*8 +: 8] & mux_m[g*8 +: 8]);
        return r & en_m;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h40) en_m[31:0] = d;
        if (a == 8'h44) en_m[63:32] = d;
        for (int w = 0; w < 4; w++)
            if (a == 8'hC0 + 8'(4*w)) mux_m[w*32 +: 32] = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e; it.req = req;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: pops the expected word when read data is due
    always @(posedge clk) begin
        if (rst_n && bus_rd) begin
            item_t it;
            #2;
            if (sb_q.size() == 0) chk(1'b0, "scoreboard-empty", bus_rdata, 32'h0);
            else begin
                it = sb_q.pop_front();
                chk(bus_rdata === it.exp, it.req, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wake_o == 1'b0, "R1 wake", {31'b0, wake_o}, 32'h0);
        chk(nmi_clr_o == 1'b0, "R1 nmi_clr", {31'b0, nmi_clr_o}, 32'h0);
        rd(8'h40, 32'h0, "R1 en0");
        rd(8'h44, 32'h0, "R1 en1");
        for (int w = 0; w < 4; w++) rd(8'hC0 + 8'(4*w), 32'h0, "R1 muxen");

        // R2/R3: storage and readback
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'hC4, 32'hA5A5_0F0F);
        rd(8'h44, 32'hFFFF_FFFF, "R2 en1");
        rd(8'hC4, 32'hA5A5_0F0F, "R3 muxen1");
        // R6: upper pending bits never set
        mux_in = '1; direct_in = '1; nmi_in = 1'b1;
        rd(8'h14, 32'h0, "R6 pend1");

        // R4: pending = source & enable, two patterns
        mux_in = '0; direct_in = '0; nmi_in = 1'b0;
        wr(8'h40, 32'h0007_A005);
        nmi_in = 1'b1; direct_in = 18'h2_0003;
        p = exp_pending();
        rd(8'h10, p[31:0], "R4 pattern a");
        nmi_in = 1'b0; direct_in = 18'h0_3FFC;
        p = exp_pending();
        rd(8'h10, p[31:0], "R4 pattern b");
        @(negedge clk);
        chk(wake_o == |exp_pending(), "R7 wake direct", {31'b0, wake_o}, {31'b0, |exp_pending()});

        // R5: muxed gating
        direct_in = '0;
        wr(8'h40, 32'hFFF8_0000);
        wr(8'hC0, 32'h0000_0400);
        mux_in[10] = 1'b1;
        rd(8'h10, 32'h0010_0000, "R5 line10 on");
        wr(8'hC0, 32'h0000_0000);
        rd(8'h10, 32'h0, "R5 line10 gated");
        @(negedge clk);
        chk(wake_o == 1'b0, "R7 wake low", {31'b0, wake_o}, 32'h0);
        wr(8'hCC, 32'h0000_0080);
        mux_in[103] = 1'b1;
        rd(8'h10, 32'h8000_0000, "R5 line103");
        @(negedge clk);
        chk(wake_o == 1'b1, "R7 wake mux", {31'b0, wake_o}, 32'h1);

        // R8/R9: clear strobe
        wr(8'h10, 32'hFFFF_FFFF);
        chk(nmi_clr_o == 1'b1, "R8 pulse", {31'b0, nmi_clr_o}, 32'h1);
        @(negedge clk);
        chk(nmi_clr_o == 1'b0, "R8 pulse end", {31'b0, nmi_clr_o}, 32'h0);
        rd(8'h10, 32'h8000_0000, "R9 pend kept");
        wr(8'h10, 32'hFFFF_FFFE);
        chk(nmi_clr_o == 1'b0, "R8 no pulse", {31'b0, nmi_clr_o}, 32'h0);

        // R10: undefined offsets
        wr(8'h50, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'hD0, 32'h0);
        rd(8'h40, 32'hFFF8_0000, "R10 en0 kept");
        rd(8'hCC, 32'h0000_0080, "R10 muxen3 kept");
        rd(8'h50, 32'h0, "R10 read zero");
        rd(8'h42, 32'h0, "R10 unaligned zero");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule